// File: doc/BRIEF.md
# Stereo / Mono Audio Serial Frame Transmitter

This block turns parallel audio samples into a two-wire-plus-clock serial stream: a bit clock (`sck`) made from the system clock, a word-select line (`ws`) and one data line (`sd`). Each of the two channels offers its sample through a valid/ready handshake into a single holding register. The framer moves that register into the shift path only when a channel slot begins, so a word that is being sent is never disturbed by new input.

Word length is set at run time, from 8 to 32 bits. The sample is right-aligned in the input word, and bits above the word length are ignored. The data is sent most significant bit first. A framing input picks between I2S timing, where the data lags the word-select edge by one bit clock, and left-justified timing, where the data starts in the same bit period as the edge. In stereo, word-select is a square wave with one slot per channel. A mono option makes every slot carry a left-channel word and turns word-select into a pulse that lasts one bit clock.

If a channel slot starts while its holding register is empty, the previous word for that channel is sent again and a sticky underflow flag is raised. The configuration inputs are meant to be set while reset is asserted.

Top module: `audio_frame_tx`

## Requirements
- R1: The effective word length is `cfg_word_len` clamped to the range 8..32. Each word sends bits [len-1:0] of the sample, most significant first. Sample bits at and above len have no effect on `sd`.
- R2: With `cfg_left_just`=0 (I2S), the first bit period of a slot carries the least significant bit of the previous slot's word, or 0 for the first slot after reset. Bit k (k ≥ 1) of the slot carries sample bit len-k.
- R3: With `cfg_left_just`=1, bit k of a slot (k = 0..len-1) carries sample bit len-1-k. The MSB is therefore in the same bit period as the word-select edge.
- R4: In stereo (`cfg_mono`=0), `ws` is 0 for left slots and 1 for right slots. Each slot is len bit clocks long, and the first slot after reset is a left slot.
- R5: In mono (`cfg_mono`=1), every slot carries a left-channel word, and `ws` is 1 only during the first bit period of each slot. `r_ready` stays 0, so right-channel input is never taken.
- R6: `sck` is low after reset and has a period of exactly 2*(`cfg_div`+1) system clocks.
- R7: `ws` and `sd` change only in the system-clock cycle in which `sck` falls. A receiver can therefore sample them on the rising edge of `sck`.
- R8: Each channel has one holding register. `*_ready` is 1 exactly when that register is empty and the channel is enabled. After a transfer, ready stays 0 until the next slot of that channel starts and takes the sample.
- R9: If a slot starts with its holding register empty, the last word taken for that channel is sent again. `underflow` then goes to 1 and stays 1 until reset.
- R10: While reset is asserted, `sck`, `ws`, `sd` and `underflow` are 0 and `l_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word_len | input | 6 | Bits per channel word (clamped 8..32) |
| cfg_left_just | input | 1 | 1: left-justified timing, 0: I2S timing |
| cfg_mono | input | 1 | 1: mono with pulsed word-select |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in system clocks |
| l_data | input | SW | Left sample, right-aligned |
| l_valid | input | 1 | Left sample offered |
| l_ready | output | 1 | Left holding register empty |
| r_data | input | SW | Right sample, right-aligned |
| r_valid | input | 1 | Right sample offered |
| r_ready | output | 1 | Right holding register empty (0 in mono) |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| underflow | output | 1 | Sticky: a slot started without a fresh sample |

## Verification
The hardest case to reach from the ports is underflow. It needs a slot to begin while its holding register is empty, and that must happen after a run of clean frames, so that the repeated word can be told apart from a fresh one. The bench feeds a fixed number of samples per channel and then stops. It checks that the flag is still clear when the last fed frame finishes, and that the following frame repeats the final words and sets the flag. The I2S carry bit at a slot start depends on the word before it, so every framing and mode combination is swept with several word lengths. The sweep includes the clamped lengths.

// File: rtl/aft_pkg.sv
package aft_pkg;

    localparam int MAX_W  = 32;
    localparam int MIN_W  = 8;
    localparam int LEN_W  = 6;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    typedef struct packed {
        logic             lj;
        logic             mono;
        logic [LEN_W-1:0] len;
    } frame_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] raw);
        if (raw < LEN_W'(MIN_W))
            return LEN_W'(MIN_W);
        else if (raw > LEN_W'(MAX_W))
            return LEN_W'(MAX_W);
        else
            return raw;
    endfunction

endpackage

// File: rtl/aft_clkgen.sv
module aft_clkgen
    import aft_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output sck_evt_t         evt
);

    logic [DIV_W-1:0] cnt_q;
    logic             sck_q;
    logic             wrap;

    assign wrap = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sck      = sck_q;
    assign evt.rise = wrap & ~sck_q;
    assign evt.fall = wrap &  sck_q;

    AST_SCK_STEADY: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != div) |=> $stable(sck_q)); // R6

endmodule

// File: rtl/aft_holding.sv
module aft_holding #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         take,
    output logic [W-1:0] out_data,
    output logic         out_full
);

    logic [W-1:0] data_q;
    logic         full_q;
    logic         accept;

    assign in_ready = en & ~full_q;
    assign accept   = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (accept) begin
            data_q <= in_data;
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign out_data = data_q;
    assign out_full = full_q;

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (full_q && !take) |=> ($stable(data_q) && full_q)); // R8

endmodule

// File: rtl/aft_framer.sv
module aft_framer
    import aft_pkg::*;
#(
    parameter int W  = MAX_W,
    parameter int IW = LEN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  frame_cfg_t   cfg,
    input  logic         fall,
    input  logic [W-1:0] word_l,
    input  logic [W-1:0] word_r,
    input  logic         full_l,
    input  logic         full_r,
    output logic         take_l,
    output logic         take_r,
    output logic         ws,
    output logic         sd,
    output logic         underflow
);

    localparam int PW = $clog2(W);

    logic [IW-1:0] len;
    logic [IW-1:0] bit_q, bit_n, pos;
    logic          slot_end;
    chan_e         chan_q, chan_n;
    logic [W-1:0]  shreg_q, word_n;
    logic          src_full;
    logic          lj_bit;
    logic          prev_q, ws_q, sd_q, uf_q;

    assign len      = clamp_len(cfg.len);
    assign slot_end = (bit_q >= len - 1'b1);

    always_comb begin
        bit_n    = slot_end ? '0 : bit_q + 1'b1;
        chan_n   = chan_q;
        word_n   = shreg_q;
        src_full = 1'b1;
        if (slot_end) begin
            chan_n = cfg.mono ? CH_LEFT : chan_e'(~chan_q);
            if (chan_n == CH_LEFT) begin
                word_n   = word_l;
                src_full = full_l;
            end else begin
                word_n   = word_r;
                src_full = full_r;
            end
        end
        pos    = len - 1'b1 - bit_n;
        lj_bit = word_n[pos[PW-1:0]];
    end

    assign take_l = fall & slot_end & (chan_n == CH_LEFT);
    assign take_r = fall & slot_end & (chan_n == CH_RIGHT);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q   <= '1;
            chan_q  <= CH_RIGHT;
            shreg_q <= '0;
            prev_q  <= 1'b0;
            ws_q    <= 1'b0;
            sd_q    <= 1'b0;
            uf_q    <= 1'b0;
        end else if (fall) begin
            bit_q   <= bit_n;
            chan_q  <= chan_n;
            shreg_q <= word_n;
            prev_q  <= lj_bit;
            sd_q    <= cfg.lj ? lj_bit : prev_q;
            ws_q    <= cfg.mono ? (bit_n == '0) : (chan_n == CH_RIGHT);
            if (slot_end && !src_full)
                uf_q <= 1'b1;
        end
    end

    assign ws        = ws_q;
    assign sd        = sd_q;
    assign underflow = uf_q;

    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(sd_q)); // R7
    AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(ws_q)); // R7
    AST_MONO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cfg.mono && fall && ws_q) |=> !ws_q); // R5
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        uf_q |=> uf_q); // R9
    AST_SINGLE_TAKE: assert property (@(posedge clk) disable iff (rst)
        !(take_l && take_r)); // R4

endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
    import aft_pkg::*;
#(
    parameter int SW    = MAX_W,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       cfg_word_len,
    input  logic             cfg_left_just,
    input  logic             cfg_mono,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [SW-1:0]    l_data,
    input  logic             l_valid,
    output logic             l_ready,
    input  logic [SW-1:0]    r_data,
    input  logic             r_valid,
    output logic             r_ready,
    output logic             sck,
    output logic             ws,
    output logic             sd,
    output logic             underflow
);

    localparam int NCH = 2;

    frame_cfg_t       cfg;
    sck_evt_t         evt;
    logic [SW-1:0]    in_data  [NCH];
    logic [SW-1:0]    hold_dat [NCH];
    logic [NCH-1:0]   in_valid, in_ready, hold_full, take, ch_en;

    assign cfg.lj   = cfg_left_just;
    assign cfg.mono = cfg_mono;
    assign cfg.len  = cfg_word_len;

    assign in_data[0] = l_data;
    assign in_data[1] = r_data;
    assign in_valid   = {r_valid, l_valid};
    assign ch_en      = {~cfg_mono, 1'b1};
    assign l_ready    = in_ready[0];
    assign r_ready    = in_ready[1];

    aft_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk (clk),
        .rst (rst),
        .div (cfg_div),
        .sck (sck),
        .evt (evt)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_hold
        aft_holding #(.W(SW)) u_hold (
            .clk      (clk),
            .rst      (rst),
            .en       (ch_en[ch]),
            .in_data  (in_data[ch]),
            .in_valid (in_valid[ch]),
            .in_ready (in_ready[ch]),
            .take     (take[ch]),
            .out_data (hold_dat[ch]),
            .out_full (hold_full[ch])
        );
    end

    aft_framer #(.W(SW), .IW(LEN_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .fall      (evt.fall),
        .word_l    (hold_dat[0]),
        .word_r    (hold_dat[1]),
        .full_l    (hold_full[0]),
        .full_r    (hold_full[1]),
        .take_l    (take[0]),
        .take_r    (take[1]),
        .ws        (ws),
        .sd        (sd),
        .underflow (underflow)
    );

endmodule

// File: tb/audio_frame_tx_tb_top.sv
module audio_frame_tx_tb_top;

    localparam int NF   = 4;
    localparam int MAXB = (NF + 1) * 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  cfg_word_len = 6'd8;
    logic        cfg_left_just = 1'b0;
    logic        cfg_mono = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic [31:0] l_data = '0, r_data = '0;
    logic        l_valid = 1'b0, r_valid = 1'b0;
    logic        l_ready, r_ready, sck, ws, sd, underflow;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  len, bpf;
    bit  lj_r, mono_r;

    logic cap_ws [MAXB];
    logic cap_sd [MAXB];
    int   cap_cnt;
    bit   cap_en = 0;
    bit   skip_first;
    logic prev_sck = 1'b0;
    int   cyc = 0;
    int   last_rise = -1;
    int   period = 0;
    bit   rready_seen;

    always #10 clk = ~clk;

    audio_frame_tx dut_i (
        .clk(clk), .rst(rst), .cfg_word_len(cfg_word_len),
        .cfg_left_just(cfg_left_just), .cfg_mono(cfg_mono), .cfg_div(cfg_div),
        .l_data(l_data), .l_valid(l_valid), .l_ready(l_ready),
        .r_data(r_data), .r_valid(r_valid), .r_ready(r_ready),
        .sck(sck), .ws(ws), .sd(sd), .underflow(underflow)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cap_en) begin
            if (r_ready) rready_seen = 1;
            if (!prev_sck && sck) begin
                if (last_rise >= 0) period = cyc - last_rise;
                last_rise = cyc;
                if (skip_first) skip_first = 0;
                else if (cap_cnt < MAXB) begin
                    cap_ws[cap_cnt] = ws;
                    cap_sd[cap_cnt] = sd;
                    cap_cnt++;
                end
            end
        end
        prev_sck = sck;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] raw_word(input int ch, input int f);
        if (ch != 0) return 32'(f) * 32'h2545F491 + 32'h0BADF00D;
        return 32'(f) * 32'h9E3779B1 + 32'h13579BDF;
    endfunction

    function automatic logic [31:0] exp_word(input int ch, input int f);
        logic [31:0] mask;
        int ff;
        mask = (len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
        ff = (f >= NF) ? NF - 1 : f;
        return raw_word(ch, ff) & mask;
    endfunction

    function automatic void slot_word(input int s, output logic [31:0] w);
        if (mono_r) w = exp_word(0, s);
        else        w = exp_word(s % 2, s / 2);
    endfunction

    function automatic logic exp_sd(input int i);
        int s, k;
        logic [31:0] w;
        s = i / len;
        k = i % len;
        if (lj_r) begin
            slot_word(s, w);
            return w[len - 1 - k];
        end
        if (k == 0) begin
            if (s == 0) return 1'b0;
            slot_word(s - 1, w);
            return w[0];
        end
        slot_word(s, w);
        return w[len - k];
    endfunction

    function automatic logic exp_ws(input int i);
        if (mono_r) return (i % len) == 0;
        return ((i / len) % 2) == 1;
    endfunction

    task automatic feed(input int ch);
        for (int f = 0; f < NF; f++) begin
            @(negedge clk);
            if (ch == 0) begin l_data = raw_word(0, f); l_valid = 1; end
            else         begin r_data = raw_word(1, f); r_valid = 1; end
            while (!(ch == 0 ? l_ready : r_ready)) @(negedge clk);
            @(negedge clk);
            if (ch == 0) l_valid = 0; else r_valid = 0;
            if (f == 1) // R8: ready drops until the slot takes the sample
                check((ch == 0 ? l_ready : r_ready) == 1'b0, "R8", "ready after transfer",
                      int'(ch == 0 ? l_ready : r_ready), 0);
        end
    endtask

    task automatic run_cfg(input int len_in, input bit lj, input bit mono, input int div);
        int bad_sd, bad_ws, first_bad;
        string tag;
        rst = 1;
        cap_en = 0;
        l_valid = 0;
        r_valid = 0;
        cfg_word_len = 6'(len_in);
        cfg_left_just = lj;
        cfg_mono = mono;
        cfg_div = 8'(div);
        lj_r = lj;
        mono_r = mono;
        len = (len_in < 8) ? 8 : (len_in > 32 ? 32 : len_in);
        bpf = mono ? len : 2 * len;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(sck == 0 && ws == 0 && sd == 0 && underflow == 0 && l_ready == 1, "R10",
              "reset outputs", {27'd0, sck, ws, sd, underflow, l_ready}, 1);
        cap_cnt = 0;
        skip_first = 1;
        last_rise = -1;
        rready_seen = 0;
        prev_sck = 0;
        cap_en = 1;
        rst = 0;
        fork
            feed(0);
            begin
                if (mono) begin r_data = 32'hDEAD_BEEF; r_valid = 1; end
                else feed(1);
            end
        join_none
        while (cap_cnt < NF * bpf) begin @(negedge clk); #1; end
        check(underflow == 0, "R9", "no underflow while fed", int'(underflow), 0);
        while (cap_cnt < (NF + 1) * bpf) begin @(negedge clk); #1; end
        check(underflow == 1, "R9", "underflow after starving", int'(underflow), 1);
        cap_en = 0;
        r_valid = 0;
        bad_sd = 0;
        bad_ws = 0;
        first_bad = -1;
        for (int i = 0; i < (NF + 1) * bpf; i++) begin
            if (cap_sd[i] !== exp_sd(i)) begin
                bad_sd++;
                if (first_bad < 0) first_bad = i;
            end
            if (cap_ws[i] !== exp_ws(i)) bad_ws++;
        end
        tag = lj ? "R3" : "R2";
        // R1 word length, MSB first; R2/R3 framing; R9 repeat of last word in final frame
        check(bad_sd == 0, tag, $sformatf("sd stream R1 len=%0d mono=%0d first bad bit %0d",
              len, mono, first_bad), bad_sd, 0);
        check(bad_ws == 0, mono ? "R5" : "R4", "ws pattern mismatches", bad_ws, 0);
        check(period == 2 * (div + 1), "R6", "sck period", period, 2 * (div + 1));
        if (mono)
            check(rready_seen == 0, "R5", "r_ready in mono", int'(rready_seen), 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        run_cfg(8,  0, 0, 1);
        run_cfg(8,  1, 0, 1);
        run_cfg(13, 0, 0, 2);
        run_cfg(13, 1, 1, 1);
        run_cfg(24, 0, 1, 2);
        run_cfg(32, 0, 0, 1);
        run_cfg(32, 1, 0, 3);
        run_cfg(5,  1, 0, 1);   // R1 clamp up to 8
        run_cfg(40, 0, 1, 1);   // R1 clamp down to 32
        run_cfg(16, 1, 1, 2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule